// File: doc/BRIEF.md
# SPI Boot Image Loader

After reset this block copies a boot image out of an external serial EEPROM or flash and hands it to system memory one 32-bit word at a time. It is an SPI master in mode 0 with one chip select. The image begins with a 128-byte header, made of 4-byte entries, at device address zero. The loader reads the first 16 bytes of that header at a fixed slow rate. From those bytes it learns three things: the total length of the image in words, the SPI clock divisor to use from then on, and whether the device can do a high-speed read.

The loader then ends the first transfer and opens a second one at device address 16. This second transfer runs at the divisor taken from the header and uses the read command the header selects. The rest of the image arrives in one continuous burst. Every word, the header words included, is put on a valid/ready port together with its word index, and the indexes run upward from zero. A 2-bit strap sets how many address bytes each read command carries, or turns booting off altogether. Once the last word has been accepted, the loader releases chip select and raises `done_o`.

Top module: `spi_boot_loader`

## Requirements
- R1: When `strap_i` is 00 at reset release, `disabled_o` rises after the first clock edge. Chip select then stays high, SCK stays low, and no word or `done_o` is ever produced.
- R2: Each read command carries 1, 2 or 3 address bytes, most significant byte first, for `strap_i` equal to 01, 10 or 11.
- R3: The first transfer sends command 0x03 and address 0, then reads exactly 16 data bytes. Its SCK period is 2*(SLOW_DIV+1) clocks, where SLOW_DIV = SYS_CLK_HZ/(2*SLOW_HZ)-1.
- R4: Chip select goes high between the two transfers. The second transfer reads from address 16 with an SCK period of 2*(d+1) clocks, where d is bits [9:0] of the header word at byte offset 0x08. Bits [31:10] of that word are ignored.
- R5: Bit 0 of the header word at byte offset 0x0C selects the command for the second transfer. When the bit is 1, the command is 0x0B, followed by the address and one dummy byte before data. When the bit is 0, the command is 0x03 with no dummy byte. Bits [31:1] are ignored.
- R6: Bytes are packed into words most significant byte first. Words come out in order, and `word_addr_o` runs 0, 1, 2 and so on, starting with the header words.
- R7: While `word_valid_o` is high and `word_ready_i` is low, the word and its index stay stable and SCK stays low.
- R8: The word count is bits [19:0] of the header word at byte offset 0x00, and bits [31:20] are ignored. Exactly that many words are delivered. After the last one is accepted, chip select is high and `done_o` rises.
- R9: If the word count is below 32, `error_o` rises as soon as word 0 has been received. No word is delivered, and chip select goes high.
- R10: While `rst_ni` is low, chip select is high, SCK is low, and `word_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 2 | Address width select / boot disable |
| miso_i | input | 1 | Serial data from device |
| sck_o | output | 1 | SPI clock, idle low |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to device |
| word_valid_o | output | 1 | Word available |
| word_ready_i | input | 1 | Consumer accepts word |
| word_data_o | output | 32 | Image word |
| word_addr_o | output | 20 | Word index in image |
| done_o | output | 1 | Image fully delivered |
| disabled_o | output | 1 | Boot disabled by strap |
| error_o | output | 1 | Header word count too small |

## Verification
The errors most likely to hide are a divisor or read mode captured from the wrong header word, and a byte or address count that is off by one. The first shows up as a wrong SCK period from the second rising edge of the second transfer. The second shows up as a shifted byte in the very first word. A bad word counter shows up as a missing or surplus word, or a missing `done_o`, at the end of the image. A bench flash model checks the commands, the addresses and the SCK periods. It also checks the number of clock edges in each transfer, and a scoreboard compares every delivered word and index.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  localparam int SIZE_W      = 20;
  localparam int DIV_FIELD_W = 10;
  localparam int HDR_WORDS   = 32;
  localparam int PROBE_WORDS = 4;
  localparam logic [7:0] CMD_READ = 8'h03;
  localparam logic [7:0] CMD_FAST = 8'h0B;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OFF, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_GAP, ST_DONE, ST_ERR
  } boot_st_e;
endpackage

// File: rtl/spi_boot_sck_gen.sv
module spi_boot_sck_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == div_i) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == div_i);
endmodule

// File: rtl/spi_boot_byte_eng.sv
module spi_boot_byte_eng #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       tx_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       rx_o,
  output logic             sck_o,
  output logic             mosi_o
);
  logic       active_q, sck_q, done_q, tick;
  logic [2:0] bit_q;
  logic [7:0] tx_q, rx_q;

  spi_boot_sck_gen #(.DIV_W(DIV_W)) u_sck_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (active_q),
    .div_i (div_i),
    .tick_o(tick)
  );

  // mode 0: sample on rise, shift on fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        tx_q     <= tx_i;
        bit_q    <= '0;
        sck_q    <= 1'b0;
      end else if (active_q && tick) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[6:0], miso_i};
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            tx_q  <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign busy_o = active_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sck_o  = sck_q;
  assign mosi_o = active_q & tx_q[7];
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
  import spi_boot_pkg::*;
#(
  parameter int SYS_CLK_HZ = 125_000_000,
  parameter int SLOW_HZ    = 375_000,
  parameter int DIV_W      = 16,
  parameter int GAP_CYC    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        strap_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  output logic              word_valid_o,
  input  logic              word_ready_i,
  output logic [31:0]       word_data_o,
  output logic [SIZE_W-1:0] word_addr_o,
  output logic              done_o,
  output logic              disabled_o,
  output logic              error_o
);
  localparam int SLOW_DIV = SYS_CLK_HZ / (2 * SLOW_HZ) - 1;
  localparam int GAP_W    = $clog2(GAP_CYC + 1);

  boot_st_e               st_q;
  logic                   phase_q, hs_q, valid_q;
  logic [1:0]             width_q, acnt_q, bcnt_q;
  logic [SIZE_W-1:0]      size_q, widx_q, addr_q;
  logic [DIV_FIELD_W-1:0] div_q;
  logic [23:0]            wsh_q;
  logic [31:0]            data_q;
  logic [GAP_W-1:0]       gap_q;

  logic             busy, bdone, start, end_cond, sel;
  logic [7:0]       rx, tx;
  logic [DIV_W-1:0] eng_div;
  logic [31:0]      full_w;

  assign full_w   = {wsh_q, rx};
  assign eng_div  = phase_q ? DIV_W'(div_q) : DIV_W'(SLOW_DIV);
  assign end_cond = phase_q ? (widx_q == size_q) : (widx_q == SIZE_W'(PROBE_WORDS));
  assign sel      = (st_q == ST_CMD) || (st_q == ST_ADDR) || (st_q == ST_DUMMY) ||
                    (st_q == ST_DATA);
  assign start    = !busy && !bdone &&
                    (((st_q == ST_CMD) || (st_q == ST_ADDR) || (st_q == ST_DUMMY)) ||
                     ((st_q == ST_DATA) && !valid_q && !end_cond));

  always_comb begin
    case (st_q)
      ST_CMD:  tx = (phase_q && hs_q) ? CMD_FAST : CMD_READ;
      ST_ADDR: tx = (phase_q && (acnt_q == width_q - 2'd1)) ? 8'(PROBE_WORDS * 4) : 8'h00;
      default: tx = 8'h00;
    endcase
  end

  spi_boot_byte_eng #(.DIV_W(DIV_W)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .tx_i   (tx),
    .div_i  (eng_div),
    .miso_i (miso_i),
    .busy_o (busy),
    .done_o (bdone),
    .rx_o   (rx),
    .sck_o  (sck_o),
    .mosi_o (mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      phase_q <= 1'b0;
      hs_q    <= 1'b0;
      valid_q <= 1'b0;
      width_q <= '0;
      acnt_q  <= '0;
      bcnt_q  <= '0;
      size_q  <= '0;
      widx_q  <= '0;
      addr_q  <= '0;
      div_q   <= '0;
      wsh_q   <= '0;
      data_q  <= '0;
      gap_q   <= '0;
    end else begin
      if (valid_q && word_ready_i) valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          width_q <= strap_i;
          st_q    <= (strap_i == 2'b00) ? ST_OFF : ST_CMD;
        end
        ST_CMD: if (bdone) begin
          st_q   <= ST_ADDR;
          acnt_q <= '0;
        end
        ST_ADDR: if (bdone) begin
          if (acnt_q == width_q - 2'd1) st_q <= (phase_q && hs_q) ? ST_DUMMY : ST_DATA;
          else acnt_q <= acnt_q + 2'd1;
        end
        ST_DUMMY: if (bdone) st_q <= ST_DATA;
        ST_DATA: begin
          if (bdone) begin
            bcnt_q <= bcnt_q + 2'd1;
            wsh_q  <= {wsh_q[15:0], rx};
            if (bcnt_q == 2'd3) begin
              if (!phase_q && (widx_q == '0) &&
                  (full_w[SIZE_W-1:0] < SIZE_W'(HDR_WORDS))) begin
                st_q <= ST_ERR;
              end else begin
                valid_q <= 1'b1;
                data_q  <= full_w;
                addr_q  <= widx_q;
                widx_q  <= widx_q + SIZE_W'(1);
                if (!phase_q) begin
                  case (widx_q[1:0])
                    2'd0:    size_q <= full_w[SIZE_W-1:0];
                    2'd2:    div_q  <= full_w[DIV_FIELD_W-1:0];
                    2'd3:    hs_q   <= full_w[0];
                    default: ;
                  endcase
                end
              end
            end
          end else if (!busy && !valid_q && end_cond) begin
            st_q  <= phase_q ? ST_DONE : ST_GAP;
            gap_q <= '0;
          end
        end
        ST_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GAP_W'(GAP_CYC - 1)) begin
            phase_q <= 1'b1;
            st_q    <= ST_CMD;
          end
        end
        default: ;
      endcase
    end
  end

  assign cs_no        = !sel;
  assign word_valid_o = valid_q;
  assign word_data_o  = data_q;
  assign word_addr_o  = addr_q;
  assign done_o       = (st_q == ST_DONE);
  assign disabled_o   = (st_q == ST_OFF);
  assign error_o      = (st_q == ST_ERR);
endmodule

// File: rtl/spi_boot_loader_chk.sv
module spi_boot_loader_chk
  import spi_boot_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sck_o,
  input logic              cs_no,
  input logic              word_valid_o,
  input logic              word_ready_i,
  input logic [31:0]       word_data_o,
  input logic [SIZE_W-1:0] word_addr_o,
  input logic              done_o,
  input logic              disabled_o,
  input logic              error_o
);
  assert_valid_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !word_ready_i) |=>
      (word_valid_o && $stable(word_data_o) && $stable(word_addr_o)));

  assert_sck_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !word_ready_i) |-> !sck_o);

  assert_done_cs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !word_valid_o));

  assert_flags_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, error_o, disabled_o}));

  assert_error_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (cs_no && !word_valid_o));

  assert_disabled_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disabled_o |-> (cs_no && !sck_o && !done_o && !word_valid_o));

  assert_sck_needs_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
endmodule

bind spi_boot_loader spi_boot_loader_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sck_o       (sck_o),
  .cs_no       (cs_no),
  .word_valid_o(word_valid_o),
  .word_ready_i(word_ready_i),
  .word_data_o (word_data_o),
  .word_addr_o (word_addr_o),
  .done_o      (done_o),
  .disabled_o  (disabled_o),
  .error_o     (error_o)
);

// File: tb/spi_boot_loader_tb.sv
module spi_boot_loader_tb;
  localparam int SYS_HZ   = 3_000_000;
  localparam int SLOW_DIV = SYS_HZ / (2 * 375_000) - 1;

  logic        clk, rst_n, miso, ready;
  logic [1:0]  strap;
  logic        sck, cs_n, mosi, valid, done, disabled, error;
  logic [31:0] data;
  logic [19:0] waddr;

  spi_boot_loader #(.SYS_CLK_HZ(SYS_HZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .miso_i(miso),
    .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi),
    .word_valid_o(valid), .word_ready_i(ready), .word_data_o(data), .word_addr_o(waddr),
    .done_o(done), .disabled_o(disabled), .error_o(error)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, n_rcv = 0;
  int img_size, img_div, img_hs, nab, rdy_mode;
  int txn, rise_cnt, hdr_bits, t_first;
  bit in_txn;
  logic [7:0]  cmd_sh;
  logic [23:0] addr_sh;
  logic [7:0]  cmd_log [4];
  logic [23:0] addr_log[4];
  int          per_log [4];
  int          rise_log[4];
  logic [51:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_val(input int w);
    case (w)
      0:       return 32'hABC0_0000 | 32'(img_size);
      1:       return 32'h0002_2000;
      2:       return 32'hFFFF_FC00 | 32'(img_div);
      3:       return 32'hFFFF_FFFE | 32'(img_hs);
      default: return (32'(w) * 32'h9E37_79B1) ^ 32'h1234_5678;
    endcase
  endfunction

  function automatic logic [7:0] flash_byte(input int a);
    logic [31:0] v;
    v = word_val(a / 4);
    return v[8 * (3 - (a % 4)) +: 8];
  endfunction

  initial begin clk = 0; forever #4 clk = ~clk; end
  initial forever begin @(posedge clk); cyc++; end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      ready = (rdy_mode == 0) ? 1'b1 : (((cyc / 3) % 2) == 0);
    end
  end

  // flash model
  initial forever begin
    @(negedge cs_n);
    in_txn = 1; rise_cnt = 0; hdr_bits = 1 << 30; cmd_sh = '0; addr_sh = '0;
  end
  initial forever begin
    @(posedge cs_n);
    if (in_txn) begin
      if (txn < 4) rise_log[txn] = rise_cnt;
      txn++; in_txn = 0;
    end
  end
  initial forever begin
    @(posedge sck);
    if (in_txn) begin
      rise_cnt++;
      if (rise_cnt == 1) t_first = cyc;
      if (rise_cnt == 2 && txn < 4) per_log[txn] = cyc - t_first;
      if (rise_cnt <= 8) begin
        cmd_sh = {cmd_sh[6:0], mosi};
        if (rise_cnt == 8 && txn < 4) cmd_log[txn] = cmd_sh;
      end else if (rise_cnt <= 8 + 8 * nab) begin
        addr_sh = {addr_sh[22:0], mosi};
        if (rise_cnt == 8 + 8 * nab) begin
          if (txn < 4) addr_log[txn] = addr_sh;
          hdr_bits = 8 + 8 * nab + ((cmd_sh == 8'h0B) ? 8 : 0);
        end
      end
    end
  end
  initial begin
    miso = 1'b0;
    forever begin
      @(negedge sck);
      if (in_txn && rise_cnt >= hdr_bits) begin
        automatic int j = rise_cnt - hdr_bits;
        automatic logic [7:0] b = flash_byte(int'(addr_sh) + j / 8);
        miso = b[7 - (j % 8)];
      end
    end
  end

  // scoreboard monitor
  initial begin
    automatic bit          prev_stall = 0;
    automatic logic [31:0] prev_data  = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) prev_stall = 0;
      else begin
        if (prev_stall)
          chk(valid && data == prev_data && !sck, "R7 stall hold", {31'd0, valid, data}, {32'd1, prev_data});
        if (valid && ready) begin
          n_rcv++;
          if (exp_q.size() == 0) chk(0, "R6/R9 unexpected word", {12'd0, waddr, data}, 64'd0);
          else begin
            automatic logic [51:0] e = exp_q.pop_front();
            chk({waddr, data} == e, "R6 word", {12'd0, waddr, data}, {12'd0, e});
          end
        end
        prev_stall = valid && !ready;
        prev_data  = data;
      end
    end
  end

  task automatic drive_expected();
    for (int w = 0; w < img_size; w++) exp_q.push_back({20'(w), word_val(w)});
  endtask

  task automatic apply_reset(input logic [1:0] s);
    rst_n = 0; strap = s; nab = int'(s); txn = 0; in_txn = 0; n_rcv = 0;
    exp_q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cs_n && !sck && !valid && !done, "R10 reset state",
        {60'd0, cs_n, sck, valid, done}, 64'h8);
  endtask

  task automatic run_boot(input logic [1:0] s, input int size, input int dv, input int hs, input int rm);
    img_size = size; img_div = dv; img_hs = hs; rdy_mode = rm;
    apply_reset(s);
    drive_expected();
    rst_n = 1;
    wait (done || error);
    @(negedge clk); @(negedge clk);
    chk(done && !error, "R8 done", {62'd0, done, error}, 64'h2);
    chk(cs_n, "R8 cs released", 64'(cs_n), 64'd1);
    chk(n_rcv == size, "R8 word count", 64'(n_rcv), 64'(size));
    chk(exp_q.size() == 0, "R8 all words", 64'(exp_q.size()), 64'd0);
    chk(txn == 2, "R4 two transfers", 64'(txn), 64'd2);
    chk(cmd_log[0] == 8'h03, "R3 first cmd", 64'(cmd_log[0]), 64'h03);
    chk(addr_log[0] == 24'd0, "R3 first addr", 64'(addr_log[0]), 64'd0);
    chk(per_log[0] == 2 * (SLOW_DIV + 1), "R3 slow period", 64'(per_log[0]), 64'(2 * (SLOW_DIV + 1)));
    chk(rise_log[0] == 8 * (1 + nab + 16), "R2 first edges", 64'(rise_log[0]), 64'(8 * (1 + nab + 16)));
    chk(cmd_log[1] == (hs ? 8'h0B : 8'h03), "R5 second cmd", 64'(cmd_log[1]), hs ? 64'h0B : 64'h03);
    chk(addr_log[1] == 24'd16, "R4 second addr", 64'(addr_log[1]), 64'd16);
    chk(per_log[1] == 2 * (dv + 1), "R4 fast period", 64'(per_log[1]), 64'(2 * (dv + 1)));
    chk(rise_log[1] == 8 * (1 + nab + hs + 4 * (size - 4)), "R2/R5 second edges",
        64'(rise_log[1]), 64'(8 * (1 + nab + hs + 4 * (size - 4))));
  endtask

  initial begin
    rdy_mode = 0; img_size = 32; img_div = 0; img_hs = 0; nab = 1; txn = 0;
    strap = 2'b01; rst_n = 0;

    run_boot(2'b01, 40, 2, 0, 1);
    run_boot(2'b10, 36, 1, 1, 0);
    run_boot(2'b11, 32, 0, 0, 1);
    run_boot(2'b11, 34, 3, 1, 1);

    // R1: boot disabled
    img_size = 40; rdy_mode = 0;
    apply_reset(2'b00);
    rst_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(disabled, "R1 disabled flag", 64'(disabled), 64'd1);
    repeat (200) @(negedge clk);
    chk(txn == 0 && cs_n && !sck, "R1 no spi activity", {31'd0, cs_n, 32'(txn)}, 64'h1_0000_0000);
    chk(n_rcv == 0 && !done, "R1 no words", 64'(n_rcv), 64'd0);

    // R9: undersized image
    img_size = 5; img_div = 1; img_hs = 0; rdy_mode = 0;
    apply_reset(2'b10);
    rst_n = 1;
    wait (done || error);
    @(negedge clk);
    chk(error && !done, "R9 error flag", {62'd0, error, done}, 64'h2);
    chk(cs_n, "R9 cs released", 64'(cs_n), 64'd1);
    repeat (50) @(negedge clk);
    chk(n_rcv == 0, "R9 no words", 64'(n_rcv), 64'd0);
    chk(txn == 1, "R9 single transfer", 64'(txn), 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule